// File: doc/BRIEF.md
# Disk Controller Host Data FIFO

This block sits between a host processor bus and the disk-side byte stream of a floppy disk controller. It buffers data bytes in a small FIFO and tells the host when to move data. It does this through two status bits: a ready bit, which says a data-port access will be served, and a direction bit, which says whether bytes flow from the controller to the host or the other way. The command sequencer drives the direction. The disk side pushes or pops bytes through a plain strobe interface.

The host sees an eight-byte register window. The window holds an operation register, a status read that shares its offset with a data-rate write, a data port, and a control write that shares its offset with a disk-change read. The block comes out of hardware reset in a legacy mode: only one byte is buffered, and every byte raises a request. A configure pulse switches the block to full FIFO operation and sets a service threshold. A larger threshold gives the host more time before an overrun or underrun. That time in microseconds is threshold × 8 / rate(Mb/s) − 1.5, so at 1 Mb/s a threshold of 1 gives 6.5 µs and a threshold of 2 gives 14.5 µs.

A software reset is started from either of two registers. It empties the FIFO. It also drops back to legacy mode, unless the configure pulse set a lock flag.

Top module: `fdc_host_fifo`

## Requirements
- R1: In FIFO mode the block stores up to 16 bytes, and bytes leave in the order they arrived. A host write to the data port when the FIFO is full is dropped.
- R2: After hardware reset the block is in legacy mode with threshold 1 and lock 0. The FIFO is empty, overrun is 0, the operation register reads 0x04, and the rate and control registers are 0.
- R3: In legacy mode the block holds at most one byte. Ready is 1 when the direction is controller-to-host and a byte is held, or when the direction is host-to-controller and no byte is held.
- R4: In FIFO mode the threshold is T = cfg_thresh + 1, in the range 1 to 16. Ready is 1 when the direction is controller-to-host and the count is at least T, or when the direction is host-to-controller and the free space is at least T.
- R5: A cfg_load pulse loads the FIFO enable, the threshold code and the lock flag. It also discards every byte held.
- R6: A software reset empties the FIFO and clears overrun. It is started by writing the operation register (offset 2) with bit 2 = 0, or by writing the rate register (offset 4) with bit 7 = 1. With lock 0 it restores legacy mode and threshold 1. With lock 1 the enable and the threshold are kept.
- R7: Reading offset 4 returns ready on bit 7 and direction on bit 6, with the other bits 0. The direction output follows dir_to_host (1 = controller to host).
- R8: At the data port (offset 5), a read while the direction is 1 returns the oldest byte and removes it. A write while the direction is 0 adds a byte. A transfer against the direction is ignored, and a read then returns 0, as does a read of an empty FIFO.
- R9: Overrun becomes 1 when the disk side pushes into a full FIFO while the direction is 1, or pops from an empty FIFO while the direction is 0. The rejected byte is dropped. Only a hardware or software reset clears the flag.
- R10: Reading offset 7 returns the inverted disk-change input on bit 7 and 0 on the other bits. Offset 2 reads back the operation register. Offsets 0, 1, 3 and 6 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational on offset) |
| cfg_load | input | 1 | Configure pulse |
| cfg_fifo_en | input | 1 | FIFO enable value to load |
| cfg_thresh | input | 4 | Threshold code (threshold minus one) |
| cfg_lock | input | 1 | Lock flag to load |
| dir_to_host | input | 1 | Direction from the sequencer, 1 = controller to host |
| disk_push | input | 1 | Disk-side byte push |
| disk_wdata | input | 8 | Disk-side push data |
| disk_pop | input | 1 | Disk-side byte pop |
| disk_rdata | output | 8 | Oldest byte, for the disk side |
| disk_change | input | 1 | Disk-change line |
| rqm | output | 1 | Ready for transfer |
| dio | output | 1 | Direction status |
| overrun | output | 1 | Sticky overrun/underrun flag |
| op_reg | output | 8 | Operation register contents |
| rate_cfg | output | 7 | Stored data-rate field |
| ctrl_reg | output | 8 | Control register contents |

## Verification
The assertions assume that the host never strobes read and write in the same cycle. They also assume that cfg_load never coincides with a software-reset write, and that the direction input changes only while no byte is in flight. The stimulus meets these conditions by construction: it drives one operation per cycle, and it changes direction only after a reset, a configure pulse or a full drain. Within those limits the bench deliberately drives the disk side past full and past empty, and sends host transfers against the direction, so that the overrun flag and the ignore paths are exercised.

// File: rtl/fdc_fifo_pkg.sv
package fdc_fifo_pkg;

    localparam int FIFO_DEPTH   = 16;
    localparam int BYTE_W       = 8;
    localparam int OFS_W        = 3;

    localparam logic [2:0] OFS_OPER = 3'd2;
    localparam logic [2:0] OFS_STAT = 3'd4;
    localparam logic [2:0] OFS_DATA = 3'd5;
    localparam logic [2:0] OFS_DISK = 3'd7;

    localparam int OPER_RUN_BIT   = 2;
    localparam int RATE_RST_BIT   = 7;
    localparam int STAT_RDY_BIT   = 7;
    localparam int STAT_DIR_BIT   = 6;
    localparam int DISK_CHG_BIT   = 7;

    localparam logic [BYTE_W-1:0] OPER_RESET = 8'h04;

    typedef struct packed {
        logic rd_data;
        logic wr_data;
        logic wr_oper;
        logic wr_rate;
        logic wr_ctrl;
        logic soft_rst;
    } host_strobe_t;

    function automatic logic soft_reset_req(input logic wr_oper, input logic wr_rate,
                                            input logic [BYTE_W-1:0] wdata);
        return (wr_oper && !wdata[OPER_RUN_BIT]) || (wr_rate && wdata[RATE_RST_BIT]);
    endfunction

endpackage

// File: rtl/fdc_reg_decode.sv
module fdc_reg_decode
    import fdc_fifo_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int AW = OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [W-1:0]  host_wdata,
    input  logic          rqm,
    input  logic          dio,
    input  logic          data_avail,
    input  logic [W-1:0]  head_data,
    input  logic          disk_change,
    output host_strobe_t  strobe,
    output logic [W-1:0]  host_rdata,
    output logic [W-1:0]  op_reg,
    output logic [W-2:0]  rate_cfg,
    output logic [W-1:0]  ctrl_reg
);

    always_comb begin
        strobe          = '0;
        strobe.rd_data  = host_rd && (host_addr == OFS_DATA);
        strobe.wr_data  = host_wr && (host_addr == OFS_DATA);
        strobe.wr_oper  = host_wr && (host_addr == OFS_OPER);
        strobe.wr_rate  = host_wr && (host_addr == OFS_STAT);
        strobe.wr_ctrl  = host_wr && (host_addr == OFS_DISK);
        strobe.soft_rst = soft_reset_req(strobe.wr_oper, strobe.wr_rate, host_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_reg   <= OPER_RESET;
            rate_cfg <= '0;
            ctrl_reg <= '0;
        end else begin
            if (strobe.wr_oper) op_reg   <= host_wdata;
            if (strobe.wr_rate) rate_cfg <= host_wdata[W-2:0];
            if (strobe.wr_ctrl) ctrl_reg <= host_wdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_OPER: host_rdata = op_reg;
            OFS_STAT: begin
                host_rdata[STAT_RDY_BIT] = rqm;
                host_rdata[STAT_DIR_BIT] = dio;
            end
            OFS_DATA: host_rdata = (dio && data_avail) ? head_data : '0;
            OFS_DISK: host_rdata[DISK_CHG_BIT] = !disk_change;
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fdc_mode_ctrl.sv
module fdc_mode_ctrl #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          cfg_load,
    input  logic          cfg_fifo_en,
    input  logic [TW-1:0] cfg_thresh,
    input  logic          cfg_lock,
    output logic          fifo_en,
    output logic [TW-1:0] thr_code,
    output logic          lock
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_en  <= 1'b0;
            thr_code <= '0;
            lock     <= 1'b0;
        end else if (soft_rst) begin
            if (!lock) begin
                fifo_en  <= 1'b0;
                thr_code <= '0;
            end
        end else if (cfg_load) begin
            fifo_en  <= cfg_fifo_en;
            thr_code <= cfg_thresh;
            lock     <= cfg_lock;
        end
    end

    AST_LOCK_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && lock) |=> ($stable(fifo_en) && $stable(thr_code))); // R6

    AST_UNLOCKED_SRST_LEGACY: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && !lock) |=> (!fifo_en && thr_code == '0)); // R6

endmodule

// File: rtl/fdc_fifo_core.sv
module fdc_fifo_core #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          ovr_clr,
    input  logic          fifo_en,
    input  logic          push,
    input  logic          push_from_disk,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          pop_from_disk,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          overrun
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          full, empty, do_push, do_pop, ovr_evt;

    assign cap     = fifo_en ? CW'(DEPTH) : CW'(1);
    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign ovr_evt = (push && full && push_from_disk) || (pop && empty && pop_from_disk);
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ovr_clr)        overrun <= 1'b0;
        else if (!flush && ovr_evt) overrun <= 1'b1;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R1

    AST_LEGACY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> (count <= CW'(1))); // R3

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun); // R9

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (empty && !push && !flush) |=> (count == '0)); // R8

endmodule

// File: rtl/fdc_req_logic.sv
module fdc_req_logic #(
    parameter int DEPTH = 16,
    parameter int TW    = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic          dio,
    input  logic [CW-1:0] count,
    input  logic [TW-1:0] thr_code,
    output logic          rqm
);

    logic [CW-1:0] free_slots, thr_m1;

    assign free_slots = CW'(DEPTH) - count;
    assign thr_m1     = CW'(thr_code);

    always_comb begin
        if (dio) rqm = fifo_en ? (count > thr_m1) : (count != '0);
        else     rqm = fifo_en ? (free_slots > thr_m1) : (count == '0);
    end

    AST_RQM_FULL_READ: assert property (@(posedge clk) disable iff (rst)
        (dio && fifo_en && count == CW'(DEPTH)) |-> rqm); // R4

    AST_RQM_EMPTY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!dio && count == '0) |-> rqm); // R3

endmodule

// File: rtl/fdc_host_fifo.sv
module fdc_host_fifo
    import fdc_fifo_pkg::*;
#(
    parameter int W     = BYTE_W,
    parameter int AW    = OFS_W,
    parameter int DEPTH = FIFO_DEPTH,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [W-1:0]  host_wdata,
    output logic [W-1:0]  host_rdata,
    input  logic          cfg_load,
    input  logic          cfg_fifo_en,
    input  logic [TW-1:0] cfg_thresh,
    input  logic          cfg_lock,
    input  logic          dir_to_host,
    input  logic          disk_push,
    input  logic [W-1:0]  disk_wdata,
    input  logic          disk_pop,
    output logic [W-1:0]  disk_rdata,
    input  logic          disk_change,
    output logic          rqm,
    output logic          dio,
    output logic          overrun,
    output logic [W-1:0]  op_reg,
    output logic [W-2:0]  rate_cfg,
    output logic [W-1:0]  ctrl_reg
);

    host_strobe_t  strobe;
    logic          fifo_en, lock;
    logic [TW-1:0] thr_code;
    logic [CW-1:0] count;
    logic          push, pop;
    logic [W-1:0]  push_data;

    assign dio       = dir_to_host;
    assign push      = dio ? disk_push : strobe.wr_data;
    assign push_data = dio ? disk_wdata : host_wdata;
    assign pop       = dio ? strobe.rd_data : disk_pop;

    fdc_reg_decode #(.W(W), .AW(AW)) u_decode (
        .clk, .rst, .host_addr, .host_wr, .host_rd, .host_wdata,
        .rqm, .dio, .data_avail(count != '0), .head_data(disk_rdata),
        .disk_change, .strobe, .host_rdata, .op_reg, .rate_cfg, .ctrl_reg
    );

    fdc_mode_ctrl #(.TW(TW)) u_mode (
        .clk, .rst, .soft_rst(strobe.soft_rst), .cfg_load, .cfg_fifo_en,
        .cfg_thresh, .cfg_lock, .fifo_en, .thr_code, .lock
    );

    fdc_fifo_core #(.W(W), .DEPTH(DEPTH)) u_core (
        .clk, .rst, .flush(strobe.soft_rst || cfg_load), .ovr_clr(strobe.soft_rst),
        .fifo_en, .push, .push_from_disk(dio), .push_data,
        .pop, .pop_from_disk(!dio), .head(disk_rdata), .count, .overrun
    );

    fdc_req_logic #(.DEPTH(DEPTH), .TW(TW)) u_req (
        .clk, .rst, .fifo_en, .dio, .count, .thr_code, .rqm
    );

    AST_HW_RESET_STATE: assert property (@(posedge clk)
        rst |=> (op_reg == OPER_RESET && !overrun && !fifo_en && count == '0)); // R2

endmodule

// File: tb/fdc_host_fifo_bench.sv
`timescale 1ns/1ps
module fdc_host_fifo_bench;

    localparam int DEPTH = 16;

    logic       clk = 0, rst = 1;
    logic [2:0] host_addr = 0;
    logic       host_wr = 0, host_rd = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic       cfg_load = 0, cfg_fifo_en = 0, cfg_lock = 0;
    logic [3:0] cfg_thresh = 0;
    logic       dir_to_host = 0, disk_push = 0, disk_pop = 0, disk_change = 0;
    logic [7:0] disk_wdata = 0, disk_rdata;
    logic       rqm, dio, overrun;
    logic [7:0] op_reg, ctrl_reg;
    logic [6:0] rate_cfg;

    int vectors = 0, fails = 0;
    bit done = 0;

    // reference model state
    logic [7:0] q[$];
    bit   m_en = 0, m_lock = 0, m_ovr = 0;
    int   m_th = 1;
    logic [7:0] m_or = 8'h04, m_cr = 0;
    logic [6:0] m_rate = 0;

    always #5 clk = ~clk;

    fdc_host_fifo u_fdc_host_fifo (.*);

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic bit exp_rqm();
        int n = q.size();
        if (dir_to_host) return m_en ? (n >= m_th) : (n >= 1);
        return m_en ? ((DEPTH - n) >= m_th) : (n == 0);
    endfunction

    task automatic compare();
        logic [7:0] er;
        string t;
        er = 0; t = "R10";
        case (host_addr)
            3'd2: er = m_or;
            3'd4: begin er = {exp_rqm(), dir_to_host, 6'b0}; t = "R7"; end
            3'd5: begin er = (dir_to_host && q.size() > 0) ? q[0] : 8'h00; t = "R8"; end
            3'd7: er = disk_change ? 8'h00 : 8'h80;
            default: er = 0;
        endcase
        chk(host_rdata, er, t);
        chk(rqm, exp_rqm(), m_en ? "R4" : "R3");
        chk(dio, dir_to_host, "R7");
        chk(overrun, m_ovr, "R9");
        if (q.size() > 0) chk(disk_rdata, q[0], "R1");
        chk(op_reg, m_or, "R10");
        chk(rate_cfg, m_rate, "R2");
        chk(ctrl_reg, m_cr, "R2");
    endtask

    task automatic model_step();
        bit wo, wd, sr, pushreq, popreq, accp, accq;
        int cap, n;
        logic [7:0] pd;
        if (rst) begin
            q.delete(); m_en = 0; m_lock = 0; m_th = 1; m_ovr = 0;
            m_or = 8'h04; m_rate = 0; m_cr = 0;
            return;
        end
        wo = host_wr && host_addr == 3'd2;
        wd = host_wr && host_addr == 3'd4;
        sr = (wo && !host_wdata[2]) || (wd && host_wdata[7]);
        if (wo) m_or = host_wdata;
        if (wd) m_rate = host_wdata[6:0];
        if (host_wr && host_addr == 3'd7) m_cr = host_wdata;
        if (sr) begin
            q.delete(); m_ovr = 0;
            if (!m_lock) begin m_en = 0; m_th = 1; end
        end else if (cfg_load) begin
            m_en = cfg_fifo_en; m_th = int'(cfg_thresh) + 1; m_lock = cfg_lock; q.delete();
        end else begin
            cap = m_en ? DEPTH : 1;
            n = q.size();
            if (dir_to_host) begin
                pushreq = disk_push; pd = disk_wdata; popreq = host_rd && host_addr == 3'd5;
            end else begin
                pushreq = host_wr && host_addr == 3'd5; pd = host_wdata; popreq = disk_pop;
            end
            accp = pushreq && n < cap;
            accq = popreq && n > 0;
            if (pushreq && !accp && dir_to_host) m_ovr = 1;
            if (popreq && n == 0 && !dir_to_host) m_ovr = 1;
            if (accq) void'(q.pop_front());
            if (accp) q.push_back(pd);
        end
    endtask

    task automatic cyc();
        #1;
        if (!rst) compare();
        model_step();
        @(posedge clk);
        @(negedge clk);
        host_wr = 0; host_rd = 0; cfg_load = 0; disk_push = 0; disk_pop = 0;
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1; cyc();
    endtask
    task automatic hread(input logic [2:0] a);
        host_addr = a; host_rd = 1; cyc();
    endtask
    task automatic dpush(input logic [7:0] d);
        disk_wdata = d; disk_push = 1; cyc();
    endtask
    task automatic dpop();
        disk_pop = 1; cyc();
    endtask
    task automatic configure(input bit en, input logic [3:0] code, input bit lk);
        cfg_fifo_en = en; cfg_thresh = code; cfg_lock = lk; cfg_load = 1; cyc();
    endtask
    task automatic peek_chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        #1; chk(got, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1; cyc(); cyc();
        rst = 0;
        // R2 reset state
        peek_chk(op_reg, 8'h04, "R2");
        peek_chk(overrun, 0, "R2");
        // R3 legacy, controller to host
        dir_to_host = 1; cyc();
        peek_chk(rqm, 0, "R3");
        dpush(8'hA1);
        peek_chk(rqm, 1, "R3");
        dpush(8'hB2);                       // R9 push into full legacy slot
        peek_chk(overrun, 1, "R9");
        host_addr = 3'd5; #1; chk(host_rdata, 8'hA1, "R8");
        hread(3'd5);
        hread(3'd5);                        // empty read returns 0
        peek_chk(overrun, 1, "R9");
        // R6 soft reset via operation register
        hwrite(3'd2, 8'h00);
        hwrite(3'd2, 8'h04);
        peek_chk(overrun, 0, "R6");
        // legacy host-to-controller
        dir_to_host = 0; cyc();
        hwrite(3'd5, 8'h11);
        peek_chk(rqm, 0, "R3");
        hwrite(3'd5, 8'h22);                // dropped
        peek_chk(disk_rdata, 8'h11, "R3");
        hread(3'd5);                        // against direction, ignored
        dpop();
        dpop();                             // underrun
        peek_chk(overrun, 1, "R9");
        hwrite(3'd4, 8'h80);                // R6 via rate register
        hwrite(3'd4, 8'h02);
        peek_chk(rate_cfg, 7'h02, "R2");
        // FIFO mode, threshold 4
        configure(1, 4'd3, 0);
        dir_to_host = 1; cyc();
        for (int i = 0; i < 3; i++) dpush(8'h30 + 8'(i));
        peek_chk(rqm, 0, "R4");
        for (int i = 3; i < DEPTH; i++) dpush(8'h30 + 8'(i));
        peek_chk(rqm, 1, "R4");
        dpush(8'hEE);                       // overflow
        peek_chk(overrun, 1, "R9");
        for (int i = 0; i < DEPTH; i++) begin
            host_addr = 3'd5; #1; chk(host_rdata, 8'h30 + 8'(i), "R1");
            hread(3'd5);
        end
        dir_to_host = 0; cyc();
        peek_chk(rqm, 1, "R4");
        for (int i = 0; i < 13; i++) hwrite(3'd5, 8'h50 + 8'(i));
        peek_chk(rqm, 0, "R4");
        for (int i = 0; i < 5; i++) dpop();
        for (int i = 0; i < 12; i++) hwrite(3'd5, 8'h70 + 8'(i));  // fills to 16, rest dropped
        // unlocked soft reset returns to legacy
        hwrite(3'd2, 8'h00);
        hwrite(3'd2, 8'h04);
        hwrite(3'd5, 8'h99);
        hwrite(3'd5, 8'h9A);
        peek_chk(disk_rdata, 8'h99, "R6");
        dpop();
        // locked FIFO mode, threshold 16
        configure(1, 4'd15, 1);
        peek_chk(rqm, 1, "R5");
        hwrite(3'd5, 8'h01);
        peek_chk(rqm, 0, "R4");
        hwrite(3'd4, 8'h81);                // soft reset with lock set
        peek_chk(rqm, 1, "R6");
        hwrite(3'd5, 8'h02);
        hwrite(3'd5, 8'h03);
        peek_chk(rqm, 0, "R6");
        // configure discards pending bytes
        dir_to_host = 1;
        configure(1, 4'd0, 1);
        peek_chk(rqm, 0, "R5");
        dpush(8'h44);
        peek_chk(rqm, 1, "R4");
        // register window, reserved offsets
        for (int a = 0; a < 8; a++) begin
            host_addr = 3'(a); cyc();
        end
        hwrite(3'd7, 8'h5C);
        hwrite(3'd3, 8'hFF);
        hwrite(3'd0, 8'hFF);
        hwrite(3'd6, 8'hFF);
        disk_change = 1; host_addr = 3'd7; cyc();
        peek_chk(host_rdata, 8'h00, "R10");
        disk_change = 0; cyc();
        host_addr = 3'd3; cyc();
        // hardware reset while locked
        rst = 1; cyc();
        rst = 0; cyc();
        peek_chk(op_reg, 8'h04, "R2");
        dir_to_host = 1; dpush(8'h61);
        dpush(8'h62);
        peek_chk(overrun, 1, "R2");
        repeat (3) cyc();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule